// File: doc/BRIEF.md
# Double-Word Verifying Tri-State Serial Decoder

This block receives a serial stream in which every symbol is sent as two pulses whose high times are measured in ticks. From each pair of pulses it rebuilds a ternary address symbol (zero, one or open) or a binary data bit. The leading symbols of each word form the address, which is compared symbol by symbol with a locally strapped tri-state address. The remaining symbols are data bits. A long low time on the line is treated as a gap between words and restarts symbol counting.

Nothing reaches the outputs on the strength of a single word. The active-low valid output is asserted only when two successive words carry the local address and the same data. The same data is then presented on the data bus. Release also needs two successive mismatching words. A strap selects how long the data bus holds its value. In momentary mode the bus clears when valid releases. In latched mode the bus keeps its value until newer verified data replaces it. The tick strobe comes from the same tick source that times the transmitter.

Top module: `tsd_decoder`

## Requirements
- R1: After reset, `valid_n` is 1 and `data_out` is all zeros.
- R2: A pulse whose high time spans at least `LONG_MIN` ticks is long, and any shorter pulse is short. The pulse pair long-long decodes to zero, short-short to one, and long-short to open. On `addr_cfg` the symbol codes are 0 = zero, 1 = one and 2 = open. Symbol k of a word is compared with `addr_cfg[2k+1:2k]`, and data bit j (the j-th symbol after the address) lands on `data_out[j]`.
- R3: `valid_n` falls only after two successive complete words, each with a matching address and identical data. One matching word alone leaves it high.
- R4: `valid_n` rises only after two successive complete mismatching words. A single mismatching word followed by a matching word keeps it low.
- R5: The data of a matching word is compared with the data of the previous matching word. If they differ, `data_out` keeps its value.
- R6: With `latch_mode` = 0, `data_out` becomes all zeros on the same edge where `valid_n` returns high.
- R7: With `latch_mode` = 1, `data_out` keeps its value when `valid_n` returns high, and only a newly verified word changes it.
- R8: A data symbol received as open (long-short) is taken as data bit 1.
- R9: Every address symbol must equal its configured value exactly, across all three values. Received one against configured open, and received open against configured zero, are both mismatches.
- R10: A short-long pulse pair is illegal. It makes its word a mismatch, whether it falls in the address or in the data.
- R11: A low time of more than `SYNC_GAP` ticks resets the word. A word cut short this way counts neither as a match nor as a mismatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial pulse stream from the detector (synchronised inside) |
| tick_en | input | 1 | One-cycle tick strobe used to time pulse widths |
| latch_mode | input | 1 | 0 = momentary data hold, 1 = latched data hold (static strap) |
| addr_cfg | input | 2*ADDR_SYMS | Local tri-state address, 2 bits per symbol |
| valid_n | output | 1 | Active-low verified-word indication |
| data_out | output | DATA_BITS | Verified data bits |

## Verification
The bench builds the decoder with 5 address symbols and 4 data bits, so the address/data boundary sits at an odd position and not at the default split. Words stay short, which lets each scenario step through match and mismatch streaks word by word. `LONG_MIN` = 2 and `SYNC_GAP` = 8 are kept. Long pulses are sent at 3 ticks and, in one scenario, at exactly 2 ticks to probe the classification threshold. An idle gap of 14 ticks separates words, and truncated words are made by starting a gap part-way through a word.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  // Ternary symbol codes; shared with the addr_cfg strap encoding.
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_OPEN = 2'd2,
    SYM_BAD  = 2'd3
  } sym_t;
endpackage

// File: rtl/tsd_pulse_meter.sv
// Synchronises the line, measures high and low times in ticks,
// classifies each finished pulse and flags inter-word gaps.
module tsd_pulse_meter #(
  parameter int LONG_MIN = 2,
  parameter int SYNC_GAP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  input  logic tick_en,
  output logic pulse_vld,
  output logic pulse_long,
  output logic sync_vld
);
  localparam int LIMIT = (SYNC_GAP > LONG_MIN) ? SYNC_GAP : LONG_MIN;
  localparam int CW    = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] CMAX = '1;

  logic [2:0]    rx_q;
  logic          rx_s, rx_d, rise, fall;
  logic [CW-1:0] hi_cnt, lo_cnt, hi_base, lo_base, hi_next, lo_next;

  assign rx_s = rx_q[1];
  assign rx_d = rx_q[2];
  assign rise = rx_s & ~rx_d;
  assign fall = ~rx_s & rx_d;

  always_comb begin
    hi_base = rise ? '0 : hi_cnt;
    lo_base = fall ? '0 : lo_cnt;
    hi_next = (tick_en && rx_s && hi_base != CMAX) ? hi_base + 1'b1 : hi_base;
    lo_next = (tick_en && !rx_s && lo_base != CMAX) ? lo_base + 1'b1 : lo_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q       <= '0;
      hi_cnt     <= '0;
      lo_cnt     <= '0;
      pulse_vld  <= 1'b0;
      pulse_long <= 1'b0;
      sync_vld   <= 1'b0;
    end else begin
      rx_q       <= {rx_q[1:0], rx_in};
      hi_cnt     <= hi_next;
      lo_cnt     <= lo_next;
      pulse_vld  <= fall;
      pulse_long <= (hi_cnt >= CW'(LONG_MIN));
      // one strobe at the moment the low time first exceeds SYNC_GAP ticks
      sync_vld   <= (lo_base == CW'(SYNC_GAP)) && (lo_next == CW'(SYNC_GAP + 1));
    end
  end
endmodule

// File: rtl/tsd_word_asm.sv
// Pairs pulses into symbols, compares the address part on the fly,
// collects data bits and reports each completed word.
module tsd_word_asm
  import tsd_pkg::*;
#(
  parameter int ADDR_SYMS = 10,
  parameter int DATA_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pulse_vld,
  input  logic                   pulse_long,
  input  logic                   sync_vld,
  input  logic [2*ADDR_SYMS-1:0] addr_cfg,
  output logic                   word_vld,
  output logic                   word_match,
  output logic [DATA_BITS-1:0]   word_data
);
  localparam int NSYM = ADDR_SYMS + DATA_BITS;
  localparam int IW   = $clog2(NSYM);

  logic                 half, first_long, addr_ok, in_addr, last;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] data_sr, data_next;
  sym_t                 sym, cfg_sym;
  logic                 sym_eq, ok_next;
  int                   aidx, didx;

  always_comb begin
    unique case ({first_long, pulse_long})
      2'b11:   sym = SYM_ZERO;
      2'b00:   sym = SYM_ONE;
      2'b10:   sym = SYM_OPEN;
      default: sym = SYM_BAD;
    endcase
    in_addr = int'(idx) < ADDR_SYMS;
    last    = idx == IW'(NSYM - 1);
    aidx    = in_addr ? int'(idx) : 0;
    didx    = int'(idx) - ADDR_SYMS;
    cfg_sym = sym_t'(addr_cfg[2*aidx +: 2]);
    sym_eq  = (sym == cfg_sym) && (sym != SYM_BAD);
    ok_next = addr_ok & (in_addr ? sym_eq : (sym != SYM_BAD));
    data_next = data_sr;
    if (!in_addr && didx >= 0 && didx < DATA_BITS)
      data_next[didx] = (sym != SYM_ZERO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half       <= 1'b0;
      first_long <= 1'b0;
      idx        <= '0;
      addr_ok    <= 1'b1;
      data_sr    <= '0;
      word_vld   <= 1'b0;
      word_match <= 1'b0;
      word_data  <= '0;
    end else begin
      word_vld <= 1'b0;
      if (sync_vld) begin
        half    <= 1'b0;
        idx     <= '0;
        addr_ok <= 1'b1;
        data_sr <= '0;
      end else if (pulse_vld) begin
        if (!half) begin
          half       <= 1'b1;
          first_long <= pulse_long;
        end else begin
          half <= 1'b0;
          if (last) begin
            word_vld   <= 1'b1;
            word_match <= ok_next;
            word_data  <= data_next;
            idx        <= '0;
            addr_ok    <= 1'b1;
            data_sr    <= '0;
          end else begin
            idx     <= idx + IW'(1);
            addr_ok <= ok_next;
            data_sr <= data_next;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tsd_verify.sv
// Two-word agreement for assertion, two-word disagreement for release.
module tsd_verify #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 word_vld,
  input  logic                 word_match,
  input  logic [DATA_BITS-1:0] word_data,
  input  logic                 latch_mode,
  output logic                 valid_n,
  output logic [DATA_BITS-1:0] data_out
);
  logic                 prev_ok, prev_miss;
  logic [DATA_BITS-1:0] prev_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_n   <= 1'b1;
      data_out  <= '0;
      prev_ok   <= 1'b0;
      prev_miss <= 1'b0;
      prev_data <= '0;
    end else if (word_vld) begin
      if (word_match) begin
        prev_ok   <= 1'b1;
        prev_miss <= 1'b0;
        prev_data <= word_data;
        if (prev_ok && word_data == prev_data) begin
          valid_n  <= 1'b0;
          data_out <= word_data;
        end
      end else begin
        prev_ok   <= 1'b0;
        prev_miss <= 1'b1;
        if (prev_miss) begin
          valid_n <= 1'b1;
          if (!latch_mode) data_out <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/tsd_decoder.sv
module tsd_decoder #(
  parameter int ADDR_SYMS = 10,
  parameter int DATA_BITS = 8,
  parameter int LONG_MIN  = 2,
  parameter int SYNC_GAP  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rx_in,
  input  logic                   tick_en,
  input  logic                   latch_mode,
  input  logic [2*ADDR_SYMS-1:0] addr_cfg,
  output logic                   valid_n,
  output logic [DATA_BITS-1:0]   data_out
);
  logic                 pulse_vld, pulse_long, sync_vld;
  logic                 word_vld, word_match;
  logic [DATA_BITS-1:0] word_data;

  tsd_pulse_meter #(.LONG_MIN(LONG_MIN), .SYNC_GAP(SYNC_GAP)) meter_i (
    .clk(clk), .rst(rst), .rx_in(rx_in), .tick_en(tick_en),
    .pulse_vld(pulse_vld), .pulse_long(pulse_long), .sync_vld(sync_vld)
  );

  tsd_word_asm #(.ADDR_SYMS(ADDR_SYMS), .DATA_BITS(DATA_BITS)) asm_i (
    .clk(clk), .rst(rst), .pulse_vld(pulse_vld), .pulse_long(pulse_long),
    .sync_vld(sync_vld), .addr_cfg(addr_cfg),
    .word_vld(word_vld), .word_match(word_match), .word_data(word_data)
  );

  tsd_verify #(.DATA_BITS(DATA_BITS)) verify_i (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_match(word_match),
    .word_data(word_data), .latch_mode(latch_mode),
    .valid_n(valid_n), .data_out(data_out)
  );
endmodule

// File: rtl/tsd_decoder_chk.sv
module tsd_decoder_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 latch_mode,
  input logic                 valid_n,
  input logic [DATA_BITS-1:0] data_out,
  input logic                 word_vld,
  input logic                 word_match
);
  // R3
  valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(valid_n) |-> $past(word_vld && word_match));

  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_n) |-> $past(word_vld && !word_match));

  // R5
  data_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_out) |-> $past(word_vld));

  // R6
  mom_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(valid_n) && !latch_mode) |-> (data_out == '0));

  // R7
  latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(valid_n) && latch_mode) |-> $stable(data_out));
endmodule

bind tsd_decoder tsd_decoder_chk #(.DATA_BITS(DATA_BITS)) chk_i (
  .clk(clk), .rst(rst), .latch_mode(latch_mode), .valid_n(valid_n),
  .data_out(data_out), .word_vld(word_vld), .word_match(word_match)
);

// File: tb/tsd_decoder_tb_top.sv
module tsd_decoder_tb_top;
  localparam int AS = 5;
  localparam int DB = 4;
  localparam int NS = AS + DB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_in = 1'b0;
  logic          tick_en = 1'b0;
  logic          latch_mode = 1'b0;
  logic [2*AS-1:0] addr_cfg;
  logic          valid_n;
  logic [DB-1:0] data_out;

  int errors = 0;
  int checks = 0;
  int long_ticks = 3;

  // configured address, symbol 0 in the low bits: zero, one, open, one, zero
  localparam logic [2*AS-1:0] CFG = {2'd0, 2'd1, 2'd2, 2'd1, 2'd0};
  assign addr_cfg = CFG;

  tsd_decoder #(.ADDR_SYMS(AS), .DATA_BITS(DB), .LONG_MIN(2), .SYNC_GAP(8)) dut_i (
    .clk(clk), .rst(rst), .rx_in(rx_in), .tick_en(tick_en),
    .latch_mode(latch_mode), .addr_cfg(addr_cfg),
    .valid_n(valid_n), .data_out(data_out)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1;
    latch_mode = mode;
    rx_in = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int ticks);
    rx_in = 1'b1;
    repeat (4 * ticks) @(negedge clk);
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic symbol(input logic [1:0] code);
    case (code)
      2'd0: begin pulse(long_ticks); pulse(long_ticks); end
      2'd1: begin pulse(1); pulse(1); end
      2'd2: begin pulse(long_ticks); pulse(1); end
      default: begin pulse(1); pulse(long_ticks); end
    endcase
  endtask

  task automatic gap();
    rx_in = 1'b0;
    repeat (4 * 14) @(negedge clk);
  endtask

  // word given as symbol codes, symbol 0 in the low bits; nsym < NS truncates
  task automatic send(input logic [2*NS-1:0] w, input int nsym);
    gap();
    for (int i = 0; i < nsym; i++) symbol(w[2*i +: 2]);
    gap();
  endtask

  function automatic logic [2*NS-1:0] mk(input logic [2*AS-1:0] a, input logic [DB-1:0] d);
    logic [2*DB-1:0] dc;
    for (int j = 0; j < DB; j++) dc[2*j +: 2] = {1'b0, d[j]};
    return {dc, a};
  endfunction

  localparam logic [2*AS-1:0] MIS_A = {2'd0, 2'd1, 2'd2, 2'd1, 2'd1};

  task automatic good(input logic [DB-1:0] d); send(mk(CFG, d), NS); endtask
  task automatic miss(); send(mk(MIS_A, 4'h0), NS); endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1", "valid_n after reset", int'(valid_n), 1);
    chk("R1", "data after reset", int'(data_out), 0);
  endtask

  task automatic t_verify();
    good(4'b1010);
    chk("R3", "valid after one word", int'(valid_n), 1);
    good(4'b1010);
    chk("R3", "valid after two words", int'(valid_n), 0);
    chk("R2", "decoded data", int'(data_out), 4'b1010);
  endtask

  task automatic t_release();
    miss();
    chk("R4", "valid after one mismatch", int'(valid_n), 0);
    good(4'b1010);
    miss();
    chk("R4", "isolated mismatch", int'(valid_n), 0);
    miss();
    chk("R4", "valid after two mismatches", int'(valid_n), 1);
    chk("R6", "momentary clear", int'(data_out), 0);
  endtask

  task automatic t_data_agree();
    good(4'b0011);
    good(4'b0101);
    chk("R5", "valid with differing data", int'(valid_n), 1);
    chk("R5", "data with differing data", int'(data_out), 0);
    good(4'b0101);
    chk("R5", "valid after agreement", int'(valid_n), 0);
    chk("R5", "data after agreement", int'(data_out), 4'b0101);
    good(4'b1111);
    chk("R5", "data kept on single new value", int'(data_out), 4'b0101);
    good(4'b1111);
    chk("R5", "data replaced", int'(data_out), 4'b1111);
  endtask

  task automatic t_open_data();
    logic [2*NS-1:0] w;
    miss(); miss();
    // data symbols: open, zero, open, zero -> bits 0101
    w = {2'd0, 2'd2, 2'd0, 2'd2, CFG};
    send(w, NS);
    send(w, NS);
    chk("R8", "valid with open data", int'(valid_n), 0);
    chk("R8", "open decoded as one", int'(data_out), 4'b0101);
  endtask

  task automatic t_addr_tri();
    logic [2*AS-1:0] a1, a2;
    a1 = CFG; a1[5:4] = 2'd1;   // one where open expected
    a2 = CFG; a2[1:0] = 2'd2;   // open where zero expected
    send(mk(a1, 4'b0101), NS);
    send(mk(a1, 4'b0101), NS);
    chk("R9", "one vs open releases", int'(valid_n), 1);
    good(4'b0110); good(4'b0110);
    chk("R9", "re-verified", int'(valid_n), 0);
    send(mk(a2, 4'b0110), NS);
    send(mk(a2, 4'b0110), NS);
    chk("R9", "open vs zero releases", int'(valid_n), 1);
  endtask

  task automatic t_illegal();
    logic [2*NS-1:0] w;
    good(4'b1100); good(4'b1100);
    chk("R10", "verified before illegal", int'(valid_n), 0);
    w = mk(CFG, 4'b1100); w[2*(AS+2) +: 2] = 2'd3;
    send(w, NS); send(w, NS);
    chk("R10", "illegal data symbol releases", int'(valid_n), 1);
    good(4'b1100); good(4'b1100);
    w = mk(CFG, 4'b1100); w[3:2] = 2'd3;
    send(w, NS); send(w, NS);
    chk("R10", "illegal address symbol releases", int'(valid_n), 1);
  endtask

  task automatic t_trunc();
    good(4'b0001); good(4'b0001);
    miss();
    send(mk(MIS_A, 4'h0), 6);
    chk("R11", "truncated not a mismatch", int'(valid_n), 0);
    miss();
    chk("R11", "truncated not a match", int'(valid_n), 1);
    good(4'b0010);
    send(mk(CFG, 4'b0010), 6);
    good(4'b0010);
    chk("R11", "truncated keeps match streak", int'(valid_n), 0);
    chk("R11", "data after streak", int'(data_out), 4'b0010);
  endtask

  task automatic t_latch();
    do_reset(1'b1);
    chk("R1", "valid_n after reset (latch)", int'(valid_n), 1);
    good(4'b0110); good(4'b0110);
    chk("R7", "latched data", int'(data_out), 4'b0110);
    miss(); miss();
    chk("R7", "valid released", int'(valid_n), 1);
    chk("R7", "data held after release", int'(data_out), 4'b0110);
    good(4'b1001);
    chk("R7", "data held on one word", int'(data_out), 4'b0110);
    good(4'b1001);
    chk("R7", "data replaced", int'(data_out), 4'b1001);
    long_ticks = 2;
    good(4'b0000); good(4'b0000);
    chk("R2", "two-tick pulse is long", int'(data_out), 4'b0000);
    chk("R2", "valid at threshold", int'(valid_n), 0);
    long_ticks = 3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_verify();
    t_release();
    t_data_agree();
    t_open_data();
    t_addr_tri();
    t_illegal();
    t_trunc();
    t_latch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule